// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

A clocked, synthesizable stand-in for an asynchronous 16-bit static RAM with two independently gated byte lanes. A memory-controller testbench drives it. On every rising clock edge it samples five active-low controls: chip select, output enable, write enable, low-byte enable and high-byte enable. It also samples the address and the incoming data. From these it decides, for each byte lane, whether to store the incoming byte, drive the stored byte, or leave the lane floating.

The bidirectional bus is split into three parts: a data input, a data output, and one drive-enable bit per lane. An enclosing wrapper can rebuild a tri-state pin from these. The lane is floating when its drive-enable bit is low. Deciding whether a lane floats follows a fixed priority, from highest to lowest:

1. Deselect.
2. Write.
3. Output disable.
4. Lane disable.

A power-state output reports standby whenever the chip is deselected. The array depth is `2**ADDR_W` words. `ADDR_W` = 16 gives the full 65,536-word device, and the default is smaller so that elaboration stays cheap.

Top module: `sram_lane_model`

## Requirements
- R1: When `ce_ni` is sampled high, nothing is written, both bits of `data_oe_o` are 0 and `standby_o` is 1 after that edge, whatever the other inputs are.
- R2: When `ce_ni` and `we_ni` are sampled low, each lane whose enable is low is stored at `addr_i` on that edge. Lane 0 is `data_i[7:0]` gated by `lb_ni`, and lane 1 is `data_i[15:8]` gated by `ub_ni`. Both lanes float after that edge.
- R3: A write with only one lane enabled leaves the other byte of the addressed word unchanged.
- R4: When `ce_ni` and `oe_ni` are sampled low and `we_ni` is high, each lane whose enable is low presents its stored byte on its slice of `data_o`, and its `data_oe_o` bit is 1, one clock after the sampling edge.
- R5: During such a read, a lane whose enable is high has its `data_oe_o` bit at 0.
- R6: When selected with `we_ni` high, both lanes float if `oe_ni` is high or if both lane enables are high.
- R7: The slice of `data_o` for a lane whose `data_oe_o` bit is 0 reads all zeros.
- R8: `standby_o` is 0 after any edge at which `ce_ni` was sampled low.
- R9: While `rst_ni` is low, `data_o` and `data_oe_o` are 0 and `standby_o` is 1.
- R10: Every one of the `2**ADDR_W` addresses holds its own word, including address 0 and the highest address, with no aliasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the output registers |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| lb_ni | input | 1 | Low byte lane enable, active low |
| ub_ni | input | 1 | High byte lane enable, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | 16 | Write data, both lanes |
| data_o | output | 16 | Read data, zero on floating lanes |
| data_oe_o | output | 2 | Per-lane drive enable (bit 0 low byte, bit 1 high byte) |
| standby_o | output | 1 | 1 when deselected (standby), 0 when active |

## Verification
Every word is first filled with a hashed pattern, and each full-word read is then compared against it. Byte-lane writes and reads are mixed at the same address, which separates lane gating from word gating and catches a write that corrupts the untouched byte. Writes attempted while deselected, and reads with output disable or with both lanes disabled, show whether the float priority is ordered correctly. The two extreme addresses expose aliasing. Several thousand weighted random control patterns then cover combinations that the directed cases do not reach.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_WRITE   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_IDLE    = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_lane_pkg::*;
(
  input  logic             ce_ni,
  input  logic             oe_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] be_ni,
  output sram_mode_e       mode_o,
  output logic [LANES-1:0] wr_lane_o,
  output logic [LANES-1:0] rd_lane_o
);
  // priority: deselect, write, output disable, lane disable
  always_comb begin
    wr_lane_o = '0;
    rd_lane_o = '0;
    if (ce_ni) begin
      mode_o = MODE_STANDBY;
    end else if (!we_ni) begin
      mode_o    = MODE_WRITE;
      wr_lane_o = ~be_ni;
    end else if (!oe_ni && (be_ni != '1)) begin
      mode_o    = MODE_READ;
      rd_lane_o = ~be_ni;
    end else begin
      mode_o = MODE_IDLE;
    end
  end

  always_comb begin
    if (!$isunknown({wr_lane_o, rd_lane_o})) begin
      a_r2_no_read_in_write: assert (!((|wr_lane_o) && (|rd_lane_o)));
    end
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o,
  output logic              drive_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      drive_o <= 1'b0;
    end else begin
      drive_o <= rd_en_i;
      rdata_o <= rd_en_i ? mem_q[addr_i] : '0;
    end
  end

  a_r4_drive_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> drive_o);
  a_r7_float_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> rdata_o == '0);
endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              lb_ni,
  input  logic              ub_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  data_oe_o,
  output logic              standby_o
);
  sram_mode_e       mode;
  logic [LANES-1:0] wr_lane;
  logic [LANES-1:0] rd_lane;

  sram_ctrl_decode i_decode (
    .ce_ni     (ce_ni),
    .oe_ni     (oe_ni),
    .we_ni     (we_ni),
    .be_ni     ({ub_ni, lb_ni}),
    .mode_o    (mode),
    .wr_lane_o (wr_lane),
    .rd_lane_o (rd_lane)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_lane_array #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W)
    ) i_array (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_lane[l]),
      .rd_en_i (rd_lane[l]),
      .addr_i  (addr_i),
      .wdata_i (data_i[l*LANE_W +: LANE_W]),
      .rdata_o (data_o[l*LANE_W +: LANE_W]),
      .drive_o (data_oe_o[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) standby_o <= 1'b1;
    else         standby_o <= (mode == MODE_STANDBY);
  end

  a_r1_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (standby_o && data_oe_o == '0));
  a_r2_write_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni) |=> data_oe_o == '0);
  a_r6_disabled_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && we_ni && (oe_ni || (lb_ni && ub_ni))) |=> data_oe_o == '0);
  a_r8_active_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni |=> !standby_o);
endmodule

// File: tb/test_sram_lane_model.sv
module test_sram_lane_model;
  localparam int unsigned ADDR_W   = 10;
  localparam int unsigned DEPTH    = 1 << ADDR_W;
  localparam time         CLK_PER  = 10ns;
  localparam int unsigned WD_LIMIT = 100000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       din = '0;
  logic [15:0]       dout;
  logic [1:0]        doe;
  logic              stby;

  logic [15:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  sram_lane_model #(.ADDR_W(ADDR_W)) i_sram_lane_model (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .lb_ni(lb_n), .ub_ni(ub_n), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .standby_o(stby)
  );

  function automatic logic [15:0] pat(input int unsigned a);
    return 16'(a * 32'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic compare(input string tag, input logic [15:0] ed, input logic [1:0] eo,
                         input logic es);
    checks++;
    if (dout !== ed || doe !== eo || stby !== es) begin
      errors++;
      $display("FAIL %s: actual data=%h oe=%b stby=%b expected data=%h oe=%b stby=%b",
               tag, dout, doe, stby, ed, eo, es);
    end
  endtask

  task automatic step(input string tag, input logic c, input logic o, input logic w,
                      input logic lb, input logic ub, input int unsigned a,
                      input logic [15:0] d);
    logic [1:0]  eo;
    logic [15:0] ed;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; lb_n = lb; ub_n = ub;
    addr = ADDR_W'(a); din = d;
    @(posedge clk);
    #1;
    eo[0] = !c && w && !o && !lb;
    eo[1] = !c && w && !o && !ub;
    ed = {eo[1] ? model[a][15:8] : 8'h00, eo[0] ? model[a][7:0] : 8'h00};
    if (!c && !w) begin
      if (!lb) model[a][7:0]  = d[7:0];
      if (!ub) model[a][15:8] = d[15:8];
    end
    compare(tag, ed, eo, c);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected fewer", WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(posedge clk);
    #1;
    compare("R9 reset", 16'h0000, 2'b00, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: fill every word
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = pat(a);
      step("R2 fill", 0, 1, 0, 0, 0, a, pat(a));
    end
    // R10: extremes and full read-back
    step("R10 addr0",   0, 0, 1, 0, 0, 0, 16'h0);
    step("R10 addrmax", 0, 0, 1, 0, 0, DEPTH-1, 16'h0);
    for (int a = 0; a < DEPTH; a += 37) step("R4 full read", 0, 0, 1, 0, 0, a, 16'h0);
    // R3: byte writes
    step("R3 low write",  0, 1, 0, 0, 1, 5, 16'hABCD);
    step("R3 low check",  0, 0, 1, 0, 0, 5, 16'h0);
    step("R3 high write", 0, 0, 0, 1, 0, 5, 16'h1234);
    step("R3 high check", 0, 0, 1, 0, 0, 5, 16'h0);
    // R5, R7: single-lane reads
    step("R5 R7 low only",  0, 0, 1, 0, 1, 5, 16'h0);
    step("R5 R7 high only", 0, 0, 1, 1, 0, 5, 16'h0);
    // R6
    step("R6 oe high",     0, 1, 1, 0, 0, 5, 16'h0);
    step("R6 lanes off",   0, 0, 1, 1, 1, 5, 16'h0);
    // R1: deselected write attempt, then readback
    step("R1 deselect wr", 1, 0, 0, 0, 0, 9, 16'hDEAD);
    step("R1 no store",    0, 0, 1, 0, 0, 9, 16'h0);
    // R2: write with oe low still floats
    step("R2 write float", 0, 0, 0, 0, 0, DEPTH-1, 16'hBEEF);
    step("R10 max check",  0, 0, 1, 0, 0, DEPTH-1, 16'h0);
    step("R10 zero check", 0, 0, 1, 0, 0, 0, 16'h0);

    // random mix, R8 standby tracking throughout
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom % 16;
      logic c = (r == 0);
      logic w = !(r inside {[1:5]});
      logic o = (r == 6);
      step("R8 random", c, o, w, logic'($urandom % 3 == 0), logic'($urandom % 3 == 0),
           $urandom % DEPTH, 16'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule